// File: doc/BRIEF.md
# Masked packed integer-to-double converter

This block turns up to eight signed 32-bit integers into IEEE-754 binary64 values in a single registered step. A lane-count select picks 2, 4 or 8 lanes, which gives a result of 128, 256 or 512 bits. Element j of the source feeds result lane j. The source vector is therefore half as wide as the result.

An encoding-mode input picks one of three behaviours. In legacy mode exactly two lanes are converted and the old destination value is kept above bit 127. In plain vector mode the selected lanes are all converted and everything above them is cleared. In masked mode a per-lane mask chooses, lane by lane, between the converted value and a fallback. The fallback is the old destination value under merging or zero under zeroing. Masked mode can also broadcast the lowest source element into every active lane. Every int32 is exactly representable in binary64, so no rounding ever takes place.

The result register loads on a valid strobe and holds its value otherwise.

Top module: `i2d_convert`

## Requirements
- R1: A synchronous reset clears the whole 512-bit result to zero.
- R2: The result loads one clock after a cycle with `inValid` high and keeps its value in every cycle with `inValid` low.
- R3: Each converted lane is the exact binary64 value of its signed integer. Bit 63 is the sign, bits 62:52 hold 1023 plus the position of the leading one of the magnitude, and bits 51:0 hold the bits below that one, left-justified. Zero gives all 64 bits zero, and -2147483648 gives 0xC1E0000000000000.
- R4: Lane j converts source bits [32j+31:32j] into result bits [64j+63:64j].
- R5: `vlSel` encodes the lane count as 0 for 2 lanes, 1 for 4 lanes, and 2 or 3 for 8 lanes.
- R6: `encMode` encodes the mode as 0 for legacy, 1 for plain vector and 2 or 3 for masked. The mask takes effect only in masked mode. In the other modes every active lane is converted whatever `laneMask` holds.
- R7: In masked mode with `zeroMask` low, an active lane whose mask bit is clear takes its lane of `oldDst`.
- R8: In masked mode with `zeroMask` high, an active lane whose mask bit is clear becomes zero.
- R9: With `bcast` high in masked mode, every active lane converts source bits [31:0]. In the other modes `bcast` has no effect.
- R10: In plain vector and masked modes, result bits above the active lane count are zero.
- R11: Legacy mode converts lanes 0 and 1 whatever `vlSel` holds, and passes `oldDst[511:128]` through unchanged.
- R12: Mask bits at or above the active lane count have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Load strobe for the result register |
| srcVec | input | 256 | Packed signed 32-bit source elements |
| oldDst | input | 512 | Previous destination value, used for merging and pass-through |
| laneMask | input | 8 | Per-lane write mask |
| vlSel | input | 2 | Lane-count select |
| encMode | input | 2 | Mode: legacy, plain vector or masked |
| zeroMask | input | 1 | Masked-off lanes are zeroed when high and merged when low |
| bcast | input | 1 | Broadcast the lowest source element (masked mode only) |
| dstVec | output | 512 | Registered result vector |

## Verification
The assertions assume that the inputs are stable and known at each rising edge where `inValid` is sampled, and that `oldDst` carries the value to be merged in that same cycle. The bench changes inputs only on falling edges and holds them for a whole cycle. Every combination of mode, lane count, merge/zero and broadcast is swept with sign-mixed random elements, with masks that include bits above the lane count, and with hand-picked extreme integers. Expected results come from the simulator's own integer-to-real conversion.

// File: rtl/i2d_pkg.sv
`timescale 1ns/1ps
package i2d_pkg;
  localparam int MAX_LANES = 8;
  localparam int ELEM_W    = 32;
  localparam int RES_W     = 64;
  localparam int FRAC_W    = 52;
  localparam int EXP_W     = 11;
  localparam int EXP_BIAS  = 1023;
  localparam int SRC_W     = MAX_LANES * ELEM_W;
  localparam int DST_W     = MAX_LANES * RES_W;

  typedef enum logic [1:0] {
    ENC_LEGACY = 2'd0,
    ENC_VECTOR = 2'd1,
    ENC_MASKED = 2'd2,
    ENC_MASKX  = 2'd3
  } encMode_e;

  typedef struct packed {
    logic                 load;
    logic                 useBcast;
    logic [MAX_LANES-1:0] laneCvt;
    logic [MAX_LANES-1:0] laneKeep;
  } ctrlStrobe_t;
endpackage

// File: rtl/i2d_lane_cvt.sv
`timescale 1ns/1ps
module i2d_lane_cvt
  import i2d_pkg::*;
(
  input  logic [ELEM_W-1:0] intIn,
  output logic [RES_W-1:0]  dblOut
);
  localparam int POS_W = $clog2(ELEM_W);

  logic [ELEM_W-1:0] mag;
  logic [ELEM_W-1:0] justified;
  logic [POS_W-1:0]  leadPos;
  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;

  always_comb begin
    mag = intIn[ELEM_W-1] ? (~intIn + 1'b1) : intIn;
    leadPos = '0;
    for (int i = 0; i < ELEM_W; i++) begin
      if (mag[i]) leadPos = POS_W'(i);
    end
    justified = mag << (POS_W'(ELEM_W - 1) - leadPos);
    expField  = EXP_W'(EXP_BIAS) + EXP_W'(leadPos);
    fracField = {justified[ELEM_W-2:0], {(FRAC_W-ELEM_W+1){1'b0}}};
    if (mag == '0) dblOut = '0;
    else           dblOut = {intIn[ELEM_W-1], expField, fracField};
  end
endmodule

// File: rtl/i2d_ctrl.sv
`timescale 1ns/1ps
module i2d_ctrl
  import i2d_pkg::*;
(
  input  logic                 inValid,
  input  logic [MAX_LANES-1:0] laneMask,
  input  logic [1:0]           vlSel,
  input  logic [1:0]           encMode,
  input  logic                 zeroMask,
  input  logic                 bcast,
  output ctrlStrobe_t          strobes
);
  logic [MAX_LANES-1:0] activeMask;
  logic                 isMasked;
  logic                 isLegacy;

  always_comb begin
    isLegacy = (encMode == ENC_LEGACY);
    isMasked = encMode[1];
    if (isLegacy) activeMask = MAX_LANES'(8'h03);
    else begin
      case (vlSel)
        2'd0:    activeMask = MAX_LANES'(8'h03);
        2'd1:    activeMask = MAX_LANES'(8'h0F);
        default: activeMask = '1;
      endcase
    end
    strobes.load     = inValid;
    strobes.useBcast = isMasked & bcast;
    for (int j = 0; j < MAX_LANES; j++) begin
      if (activeMask[j]) begin
        if (isMasked && !laneMask[j]) begin
          strobes.laneCvt[j]  = 1'b0;
          strobes.laneKeep[j] = ~zeroMask;
        end else begin
          strobes.laneCvt[j]  = 1'b1;
          strobes.laneKeep[j] = 1'b0;
        end
      end else begin
        strobes.laneCvt[j]  = 1'b0;
        strobes.laneKeep[j] = isLegacy;
      end
    end
  end
endmodule

// File: rtl/i2d_datapath.sv
`timescale 1ns/1ps
module i2d_datapath
  import i2d_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobe_t      strobes,
  input  logic [SRC_W-1:0] srcVec,
  input  logic [DST_W-1:0] oldDst,
  output logic [DST_W-1:0] dstVec
);
  logic [DST_W-1:0] nextDst;
  logic [DST_W-1:0] dstReg;

  for (genvar j = 0; j < MAX_LANES; j++) begin : gLane
    logic [ELEM_W-1:0] elem;
    logic [RES_W-1:0]  conv;
    assign elem = strobes.useBcast ? srcVec[ELEM_W-1:0] : srcVec[j*ELEM_W +: ELEM_W];
    i2d_lane_cvt uCvt (.intIn(elem), .dblOut(conv));
    assign nextDst[j*RES_W +: RES_W] =
      strobes.laneCvt[j]  ? conv :
      strobes.laneKeep[j] ? oldDst[j*RES_W +: RES_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst)               dstReg <= '0;
    else if (strobes.load) dstReg <= nextDst;
  end

  assign dstVec = dstReg;
endmodule

// File: rtl/i2d_convert.sv
`timescale 1ns/1ps
module i2d_convert
  import i2d_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [SRC_W-1:0] srcVec,
  input  logic [DST_W-1:0] oldDst,
  input  logic [MAX_LANES-1:0] laneMask,
  input  logic [1:0]       vlSel,
  input  logic [1:0]       encMode,
  input  logic             zeroMask,
  input  logic             bcast,
  output logic [DST_W-1:0] dstVec
);
  ctrlStrobe_t strobes;

  i2d_ctrl uCtrl (
    .inValid(inValid), .laneMask(laneMask), .vlSel(vlSel),
    .encMode(encMode), .zeroMask(zeroMask), .bcast(bcast), .strobes(strobes)
  );

  i2d_datapath uDp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .srcVec(srcVec), .oldDst(oldDst), .dstVec(dstVec)
  );
endmodule

// File: rtl/i2d_convert_chk.sv
`timescale 1ns/1ps
module i2d_convert_chk
  import i2d_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic [SRC_W-1:0] srcVec,
  input logic [DST_W-1:0] oldDst,
  input logic [MAX_LANES-1:0] laneMask,
  input logic [1:0]       vlSel,
  input logic [1:0]       encMode,
  input logic             zeroMask,
  input logic             bcast,
  input logic [DST_W-1:0] dstVec
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> dstVec == '0); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(dstVec)); // R2

  AST_SIGN_LANE0: assert property (@(posedge clk) disable iff (rst)
    (inValid && encMode == 2'd1) |=> dstVec[63] == $past(srcVec[31])); // R3

  AST_MERGE_LANE0: assert property (@(posedge clk) disable iff (rst)
    (inValid && encMode[1] && !zeroMask && !laneMask[0]) |=> dstVec[63:0] == $past(oldDst[63:0])); // R7

  AST_ZERO_LANE0: assert property (@(posedge clk) disable iff (rst)
    (inValid && encMode[1] && zeroMask && !laneMask[0]) |=> dstVec[63:0] == '0); // R8

  AST_UPPER_ZERO_2: assert property (@(posedge clk) disable iff (rst)
    (inValid && encMode != 2'd0 && vlSel == 2'd0) |=> dstVec[511:128] == '0); // R10

  AST_UPPER_ZERO_4: assert property (@(posedge clk) disable iff (rst)
    (inValid && encMode != 2'd0 && vlSel == 2'd1) |=> dstVec[511:256] == '0); // R10

  AST_LEGACY_UPPER: assert property (@(posedge clk) disable iff (rst)
    (inValid && encMode == 2'd0) |=> dstVec[511:128] == $past(oldDst[511:128])); // R11
endmodule

bind i2d_convert i2d_convert_chk chk (.*);

// File: tb/tb_i2d_convert.sv
`timescale 1ns/1ps
module tb_i2d_convert;
  logic         clk = 1'b0;
  logic         rst;
  logic         inValid;
  logic [255:0] srcVec;
  logic [511:0] oldDst;
  logic [7:0]   laneMask;
  logic [1:0]   vlSel;
  logic [1:0]   encMode;
  logic         zeroMask;
  logic         bcast;
  logic [511:0] dstVec;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  i2d_convert dut (
    .clk(clk), .rst(rst), .inValid(inValid), .srcVec(srcVec), .oldDst(oldDst),
    .laneMask(laneMask), .vlSel(vlSel), .encMode(encMode), .zeroMask(zeroMask),
    .bcast(bcast), .dstVec(dstVec)
  );

  function automatic logic [63:0] refCvt(logic [31:0] v);
    int s;
    s = $signed(v);
    return $realtobits($itor(s));
  endfunction

  function automatic logic [511:0] refModel(logic [255:0] s, logic [511:0] o, logic [7:0] m,
                                            logic [1:0] vl, logic [1:0] md, logic zm, logic bc);
    logic [511:0] r;
    int lanes;
    logic masked;
    logic [31:0] e;
    masked = md[1];
    lanes = (md == 2'd0 || vl == 2'd0) ? 2 : (vl == 2'd1) ? 4 : 8;
    for (int j = 0; j < 8; j++) begin
      if (j < lanes) begin
        e = (masked && bc) ? s[31:0] : s[j*32 +: 32];
        if (!masked || m[j]) r[j*64 +: 64] = refCvt(e);
        else                 r[j*64 +: 64] = zm ? 64'd0 : o[j*64 +: 64];
      end else begin
        r[j*64 +: 64] = (md == 2'd0) ? o[j*64 +: 64] : 64'd0;
      end
    end
    return r;
  endfunction

  function automatic logic [255:0] randSrc();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom();
    return v;
  endfunction

  function automatic logic [511:0] randDst();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom();
    return v;
  endfunction

  task automatic check(string tag, logic [511:0] act, logic [511:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [255:0] s, logic [511:0] o, logic [7:0] m, logic [1:0] vl,
                       logic [1:0] md, logic zm, logic bc, string tag);
    logic [511:0] exp;
    @(negedge clk);
    srcVec = s; oldDst = o; laneMask = m; vlSel = vl; encMode = md;
    zeroMask = zm; bcast = bc; inValid = 1'b1;
    exp = refModel(s, o, m, vl, md, zm, bc);
    @(negedge clk);
    inValid = 1'b0;
    check(tag, dstVec, exp);
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    logic [511:0] held;
    logic [31:0] specials [10];
    logic [7:0]  masks [6];
    specials = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000,
                 32'h00010000, 32'hFFFF0000, 32'h00000003, 32'h80000001, 32'h12345678};
    masks = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'hFC, 8'h03};
    rst = 1'b1; inValid = 1'b0; srcVec = '0; oldDst = '0; laneMask = '0;
    vlSel = '0; encMode = '0; zeroMask = 1'b0; bcast = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset", dstVec, '0);
    rst = 1'b0;

    // R3: fixed encodings
    apply({224'd0, 32'h0}, randDst(), 8'h00, 2'd2, 2'd1, 1'b0, 1'b0, "R3 zero");
    check("R3 zero lane bits", {448'd0, dstVec[63:0]}, '0);
    apply({224'd0, 32'h80000000}, '0, 8'h00, 2'd0, 2'd1, 1'b0, 1'b0, "R3 minint");
    check("R3 minint pattern", {448'd0, dstVec[63:0]}, {448'd0, 64'hC1E0000000000000});

    // R3/R4: extreme values in every lane position
    for (int k = 0; k < 10; k++) begin
      logic [255:0] s;
      s = randSrc();
      s[(k % 8)*32 +: 32] = specials[k];
      apply(s, randDst(), 8'hFF, 2'd3, 2'd1, 1'b0, 1'b0, "R3/R4 specials");
    end

    // R2: idle cycles with changing inputs keep the result
    held = dstVec;
    @(negedge clk);
    srcVec = randSrc(); oldDst = randDst(); encMode = 2'd0; laneMask = 8'h00;
    @(negedge clk);
    check("R2 hold", dstVec, held);
    @(negedge clk);
    check("R2 hold second cycle", dstVec, held);

    // R5..R12: sweep every mode control combination
    for (int md = 0; md < 4; md++)
      for (int vl = 0; vl < 4; vl++)
        for (int zm = 0; zm < 2; zm++)
          for (int bc = 0; bc < 2; bc++)
            for (int mi = 0; mi < 6; mi++)
              for (int rep = 0; rep < 3; rep++)
                apply(randSrc(), randDst(), masks[mi], 2'(vl), 2'(md), 1'(zm), 1'(bc),
                      "R5/R6/R7/R8/R9/R10/R11/R12 sweep");

    // R12: mask bits above the lane count vary, result must match the cleared-upper mask
    for (int u = 0; u < 16; u++) begin
      logic [255:0] s;
      logic [511:0] o;
      logic [511:0] ref4;
      s = randSrc(); o = randDst();
      ref4 = refModel(s, o, 8'h05, 2'd1, 2'd2, 1'b1, 1'b0);
      apply(s, o, {4'(u), 4'h5}, 2'd1, 2'd2, 1'b1, 1'b0, "R12 upper mask bits");
      check("R12 upper mask equivalence", dstVec, ref4);
    end

    done = 1'b1;
    report();
  end
endmodule